// File: doc/BRIEF.md
# Flash Row-Erase Controller

This block erases one row of on-chip program flash, or one of the few user-ID words, when the CPU asks for it through four byte-wide registers: control, address low, address high and key. Software loads a 15-bit target address, selects the region, sets the erase-select and write-enable bits, then writes the two key bytes 0x55 and 0xAA to the key register. Only after that does it set the start bit. Any break in that order leaves the block idle.

A started erase holds the CPU stall output for a fixed number of clock cycles, set by `ERASE_CYCLES`. In the last of those cycles it strobes the flash array with the row index and the region. It then raises its completion flag, and raises an interrupt request if the interrupt enable is set. A target that is write-protected is refused: the start bit stays clear and nothing else happens. In program flash, every row below the `prot_rows` input is protected. In the user-ID region, every address at 4 or above is protected.

Top module: `nvm_row_eraser`

## Requirements
- R1: After reset, all four registers read 0x00, and `cpu_stall`, `irq` and `fl_erase` are low. Register select codes:
  - 0 is control, with bit0 region (1 = user-ID), bit1 erase-select, bit2 write-enable, bit3 start, bit4 done flag and bit5 interrupt enable.
  - 1 is address low byte.
  - 2 is address high bits [14:8].
  - 3 is key, which reads 0.
- R2: An erase starts only if the register write just before the start write was a key write of 0xAA, and the write before that was a key write of 0x55. Any other value, order or intervening register write means no erase.
- R3: A start write whose data lacks erase-select (bit1) or write-enable (bit2) is ignored, and start reads back 0.
- R4: A start is refused when the target is protected. In program flash that means address[14:5] < `prot_rows`. In the user-ID region it means an address of 4 or more. A refused start gives no erase strobe, no stall and no flag, and start reads 0.
- R5: An accepted erase gives exactly one `fl_erase` strobe. `fl_row` equals address[14:5], so the low 5 bits are ignored, and `fl_uid` equals the region bit.
- R6: `cpu_stall` is high for exactly `ERASE_CYCLES` consecutive cycles, beginning the cycle after the start write. Start reads 1 throughout, and `fl_erase` is high only in the last stalled cycle.
- R7: The done flag becomes 1 when the erase ends. `irq` is high exactly when the done flag and the interrupt enable are both 1.
- R8: Write-enable keeps its value through an erase. A control write with bit4 at 0 clears the done flag.
- R9: Register writes made while `cpu_stall` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for writes |
| reg_wdata | input | 8 | Write data |
| reg_rsel | input | 2 | Register select for reads |
| reg_rdata | output | 8 | Read data (combinational) |
| prot_rows | input | ADDR_W-ROW_BITS (10) | Program-flash rows below this index are protected |
| cpu_stall | output | 1 | Holds the CPU during an erase |
| irq | output | 1 | Completion interrupt request |
| fl_erase | output | 1 | One-cycle erase strobe to the array |
| fl_uid | output | 1 | Region of the erase (1 = user-ID) |
| fl_row | output | ADDR_W-ROW_BITS (10) | Row index to erase |

## Verification
The bench sweeps rows across the whole program-flash range, including the protection boundary (rows 7 and 8 with the bound at 8) and the top address 0x7FFF. A design that compared the bound against the unaligned address, or off by one, would erase row 7 or refuse row 8. It also walks every user-ID address from 0 to 7. A wrong limit would erase past word 3 or refuse a legal word.

Broken key orders are tried: 0xAA then 0x55, a repeated 0x55, and a 0x55 followed by an address write before the 0xAA. A checker that did not reset on a foreign write would start on the third. Starts without erase-select or write-enable are also tried. Each check counts the stall cycles and erase strobes, so a timer that was off by one cycle, or a strobe that fired twice, is seen. The bench also confirms that a write during the stall leaves the address untouched.

// File: rtl/nvm_row_eraser.sv
module nvm_row_eraser #(
  parameter int ADDR_W       = 15,
  parameter int ROW_BITS     = 5,
  parameter int UID_WORDS    = 4,
  parameter int ERASE_CYCLES = 40,
  localparam int ROW_IDX_W   = ADDR_W - ROW_BITS,
  localparam int HI_W        = ADDR_W - 8,
  localparam int CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_sel,
  input  logic [7:0]           reg_wdata,
  input  logic [1:0]           reg_rsel,
  output logic [7:0]           reg_rdata,
  input  logic [ROW_IDX_W-1:0] prot_rows,
  output logic                 cpu_stall,
  output logic                 irq,
  output logic                 fl_erase,
  output logic                 fl_uid,
  output logic [ROW_IDX_W-1:0] fl_row
);

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_LO   = 2'd1;
  localparam logic [1:0] SEL_HI   = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;
  localparam logic [7:0] KEY_A    = 8'h55;
  localparam logic [7:0] KEY_B    = 8'hAA;

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_t;

  key_t             key_st;
  logic             uid_sel, erase_sel, wr_ena, int_ena, done_flag, busy;
  logic [7:0]       addr_lo;
  logic [HI_W-1:0]  addr_hi;
  logic [CNT_W-1:0] cnt;

  wire [ADDR_W-1:0] tgt     = {addr_hi, addr_lo};
  wire              wr_ok   = reg_we && !busy;
  wire              ctrl_wr = wr_ok && reg_sel == SEL_CTRL;
  wire              key_armed = key_st == K_ARMED;
  wire              go_req  = ctrl_wr && key_armed && reg_wdata[3] && reg_wdata[2] && reg_wdata[1];
  wire              blocked = reg_wdata[0] ? (tgt >= ADDR_W'(UID_WORDS))
                                           : (tgt[ADDR_W-1:ROW_BITS] < prot_rows);
  wire              launch  = go_req && !blocked;
  wire              last    = busy && cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_st <= K_IDLE;
    end else if (wr_ok) begin
      if (reg_sel != SEL_KEY)
        key_st <= K_IDLE;
      else if (key_st == K_IDLE && reg_wdata == KEY_A)
        key_st <= K_HALF;
      else if (key_st == K_HALF && reg_wdata == KEY_B)
        key_st <= K_ARMED;
      else
        key_st <= K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
    end else if (wr_ok) begin
      if (reg_sel == SEL_LO) addr_lo <= reg_wdata;
      if (reg_sel == SEL_HI) addr_hi <= reg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uid_sel   <= 1'b0;
      erase_sel <= 1'b0;
      wr_ena    <= 1'b0;
      int_ena   <= 1'b0;
      done_flag <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
    end else begin
      if (ctrl_wr) begin
        uid_sel   <= reg_wdata[0];
        erase_sel <= reg_wdata[1];
        wr_ena    <= reg_wdata[2];
        done_flag <= reg_wdata[4];
        int_ena   <= reg_wdata[5];
      end
      if (launch) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(ERASE_CYCLES - 1);
      end else if (last) begin
        busy      <= 1'b0;
        done_flag <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_rsel)
      SEL_CTRL: reg_rdata = {2'b00, int_ena, done_flag, busy, wr_ena, erase_sel, uid_sel};
      SEL_LO:   reg_rdata = addr_lo;
      SEL_HI:   reg_rdata = 8'(addr_hi);
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign cpu_stall = busy;
  assign irq       = done_flag && int_ena;
  assign fl_erase  = last;
  assign fl_uid    = uid_sel;
  assign fl_row    = tgt[ADDR_W-1:ROW_BITS];

endmodule

// File: rtl/nvm_row_eraser_chk.sv
module nvm_row_eraser_chk #(
  parameter int ROW_IDX_W    = 10,
  parameter int ERASE_CYCLES = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic                 key_armed,
  input logic                 cpu_stall,
  input logic                 fl_erase,
  input logic                 done_flag,
  input logic [ROW_IDX_W-1:0] fl_row
);
  localparam int SC_W = $clog2(ERASE_CYCLES + 2);
  logic [SC_W-1:0] st_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_cnt <= '0;
    else if (cpu_stall) st_cnt <= st_cnt + 1'b1;
    else st_cnt <= '0;
  end

  // R2
  launch_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(key_armed));
  // R6
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> st_cnt == SC_W'(ERASE_CYCLES));
  // R6
  strobe_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> cpu_stall);
  // R6
  strobe_ends_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |=> !cpu_stall);
  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> ($past(fl_erase) || $past(reg_we)));
  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && $past(cpu_stall)) |-> $stable(fl_row));
endmodule

bind nvm_row_eraser nvm_row_eraser_chk #(
  .ROW_IDX_W(ROW_IDX_W), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .key_armed(key_armed),
  .cpu_stall(cpu_stall), .fl_erase(fl_erase), .done_flag(done_flag), .fl_row(fl_row)
);

// File: tb/nvm_row_eraser_tb.sv
module nvm_row_eraser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EC   = 12;
  localparam int PROT = 8;

  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0;
  logic [1:0] reg_sel = 0, reg_rsel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [9:0] prot_rows = 10'(PROT);
  logic       cpu_stall, irq, fl_erase, fl_uid;
  logic [9:0] fl_row;

  int total = 0, bad = 0;
  int stall_n = 0, pulse_n = 0, last_row = -1, last_uid = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_row_eraser #(.ERASE_CYCLES(EC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .prot_rows(prot_rows),
    .cpu_stall(cpu_stall), .irq(irq), .fl_erase(fl_erase), .fl_uid(fl_uid), .fl_row(fl_row));

  always @(posedge clk) if (rst_n) begin
    if (cpu_stall) stall_n++;
    if (fl_erase) begin pulse_n++; last_row = int'(fl_row); last_uid = int'(fl_uid); end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    reg_rsel = s; #1; v = reg_rdata;
  endtask

  // mode: 0 proper, 1 AA/55, 2 55/55/AA, 3 55/addr/AA, 4 no write-enable, 5 no erase-select
  task automatic run(input int uid, input int addr, input int ie, input int mode, input bit busy_wr);
    logic [7:0] v, base;
    int esel, wen;
    bit prot, launch;
    esel = (mode == 5) ? 0 : 1;
    wen  = (mode == 4) ? 0 : 1;
    base = 8'(uid + 2*esel + 4*wen + 32*ie);
    prot = uid ? (addr >= 4) : ((addr >> 5) < PROT);
    launch = (mode == 0) && !prot;
    wr(1, 8'(addr)); wr(2, 8'(addr >> 8)); wr(0, base);
    case (mode)
      1: begin wr(3, 8'hAA); wr(3, 8'h55); end
      2: begin wr(3, 8'h55); wr(3, 8'h55); wr(3, 8'hAA); end
      3: begin wr(3, 8'h55); wr(1, 8'(addr)); wr(3, 8'hAA); end
      default: begin wr(3, 8'h55); wr(3, 8'hAA); end
    endcase
    stall_n = 0; pulse_n = 0;
    @(negedge clk); reg_we = 1; reg_sel = 0; reg_wdata = base | 8'h08;
    @(negedge clk); reg_we = 0;
    rd(0, v);
    if (launch) begin
      chk(v[3] == 1 && cpu_stall, "R6 start/stall during erase", int'(v[3]), 1);
      if (busy_wr) begin
        reg_we = 1; reg_sel = 1; reg_wdata = 8'(~addr);
        @(negedge clk); reg_we = 0;
      end
    end
    repeat (EC + 3) @(negedge clk);
    chk(pulse_n == int'(launch), launch ? "R5 one strobe" : (mode != 0 ? (mode >= 4 ? "R3 no strobe" : "R2 no strobe") : "R4 no strobe"),
        pulse_n, int'(launch));
    chk(stall_n == (launch ? EC : 0), "R6 stall cycles", stall_n, launch ? EC : 0);
    rd(0, v);
    chk(v[3] == 0, "R3 R4 start reads 0 after", int'(v[3]), 0);
    chk(v[4] == launch, "R7 done flag", int'(v[4]), int'(launch));
    chk(irq == (launch && ie), "R7 irq", int'(irq), int'(launch && ie));
    chk(v[2] == wen[0], "R8 write-enable kept", int'(v[2]), wen);
    if (launch) begin
      chk(last_row == (addr >> 5) && last_uid == uid, "R5 row/region",
          last_row * 2 + last_uid, (addr >> 5) * 2 + uid);
      if (busy_wr) begin
        rd(1, v);
        chk(v == 8'(addr), "R9 write while stalled ignored", int'(v), addr & 255);
      end
      wr(0, base);
      rd(0, v);
      chk(v[4] == 0 && irq == 0, "R8 flag cleared", int'(v[4]), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk(v == 0, "R1 reset register value", int'(v), 0);
    end
    chk(!cpu_stall && !irq && !fl_erase, "R1 reset outputs", int'(cpu_stall) + int'(irq) + int'(fl_erase), 0);
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < 1024; r += 61) run(0, r * 32 + (r * 7) % 32, r % 2, 0, r == 61);
    run(0, 7 * 32 + 31, 1, 0, 0);
    run(0, 8 * 32, 1, 0, 0);
    run(0, 16'h7FFF, 1, 0, 1);
    for (int a = 0; a < 8; a++) run(1, a, 1, 0, 0);
    for (int m = 1; m <= 5; m++) run(0, 100 * 32 + 3, 1, m, 0);
    run(0, 100 * 32 + 3, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule